// File: doc/BRIEF.md
# Program and Erase Status Readback

This block decides what a parallel flash macro returns on its data pins during a read. While the internal operation timer reports a byte program or a block erase in progress, the block does not pass array data. It returns a status byte instead. Bit 7 is the complement of bit 7 of the byte being programmed, when the read targets that byte's address. Bit 6 flips on every new read strobe. Once the operation ends, reads return the true array contents again. The block also serves the identification reads, which return the manufacturer code, the device code and the extension code.

The operation timer pulses `op_start` when an operation begins and `op_done` when it ends. The command decoder sets `id_mode` while identification mode is active. The array supplies `arr_rdata` for the current read address in the same cycle. Array storage, command decoding and the write-back of programmed data are handled elsewhere. The read outputs are registered, so each output reflects the control pins sampled one clock earlier.

Top module: `status_readback`

## Requirements
- R1: `dq_oe` goes to 1 one clock after a cycle where `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case `dq_oe`=0 and `dq_out`=0x00 one clock later.
- R2: During a program operation, a read whose address equals the latched load address returns the inverse of the latched `ld_data_msb` on bit 7. During an erase, or at any other address, bit 7 reads 0. Bits 5..0 read 0 throughout the operation.
- R3: A read strobe is the first cycle of a read, reached by a falling `ce_n`, a falling `oe_n`, or both. Each read strobe during an operation flips bit 6. The first strobe after `op_start` returns 1. A read that is held on returns the same bit 6, and bit 6 stops changing once the operation ends.
- R4: When no operation is in progress and `id_mode`=0, a read returns `arr_rdata` on all eight bits.
- R5: When `id_mode`=1 and no operation is in progress, address 0 reads 0x1F, address 1 reads 0x07 (or 0x08 when TOP_BOOT=1), address 3 reads 0x0F, and every other address reads 0x00. During an operation, status takes priority over identification.
- R6: `op_start` latches `ld_addr` and `ld_data_msb`, latches `op_is_prog` as the operation kind, marks the block busy and clears the bit-6 toggle. `op_done` ends the busy state. When both arrive together, `op_start` wins.
- R7: Synchronous `rst`=1 clears the busy state and the toggle. One clock later it forces `dq_oe`=0 and `dq_out`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Array data for `rd_addr` |
| id_mode | input | 1 | Identification mode active |
| op_start | input | 1 | Pulse: operation begins |
| op_is_prog | input | 1 | 1 = byte program, 0 = erase (sampled with `op_start`) |
| op_done | input | 1 | Pulse: operation finished |
| ld_addr | input | AW | Address of the byte being programmed |
| ld_data_msb | input | 1 | Bit 7 of the byte being programmed |
| dq_out | output | 8 | Registered read data |
| dq_oe | output | 1 | Registered output drive enable |

## Verification
The assertions assume that `arr_rdata` belongs to the `rd_addr` presented in the same cycle. They also assume that `op_start` and `op_done` arrive as single-cycle pulses from the timer. Both are treated as free-running inputs with no ordering promise. The random stimulus chooses read addresses mostly from the latched load address and the identification addresses 0..3, so that address matches occur often. It toggles the three strobes independently and fires the start, done and reset pulses at low rates, so that operations run long enough to see several strobes. The bench models the array as a fixed function of the address, which keeps `arr_rdata` consistent with `rd_addr` in every cycle.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam logic [7:0] MFR_CODE   = 8'h1F;
  localparam logic [7:0] DEV_BOTTOM = 8'h07;
  localparam logic [7:0] DEV_TOP    = 8'h08;
  localparam logic [7:0] EXT_CODE   = 8'h0F;
  localparam logic [7:0] NO_CODE    = 8'h00;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_IDENT  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/srb_strobe.sv
module srb_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_en,
  output logic rd_strobe
);
  logic rd_q;

  assign rd_en     = ~ce_n & ~oe_n & we_n;
  assign rd_strobe = rd_en & ~rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_en;
  end
endmodule

// File: rtl/srb_toggle.sv
module srb_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic t_q,
  output logic t_next
);
  assign t_next = adv ? ~t_q : t_q;

  always_ff @(posedge clk) begin
    if (rst || clr) t_q <= 1'b0;
    else            t_q <= t_next;
  end
endmodule

// File: rtl/srb_ident.sv
module srb_ident #(
  parameter int AW       = 18,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    code
);
  import srb_pkg::*;

  logic [7:0] dev_code;
  logic       upper_zero;

  generate
    if (TOP_BOOT) begin : g_top
      assign dev_code = DEV_TOP;
    end else begin : g_bottom
      assign dev_code = DEV_BOTTOM;
    end
  endgenerate

  assign upper_zero = (addr[AW-1:2] == '0);

  always_comb begin
    code = NO_CODE;
    if (upper_zero) begin
      case (addr[1:0])
        2'd0:    code = MFR_CODE;
        2'd1:    code = dev_code;
        2'd3:    code = EXT_CODE;
        default: code = NO_CODE;
      endcase
    end
  end
endmodule

// File: rtl/status_readback.sv
module status_readback #(
  parameter int AW       = 18,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_rdata,
  input  logic          id_mode,
  input  logic          op_start,
  input  logic          op_is_prog,
  input  logic          op_done,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_data_msb,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  import srb_pkg::*;

  logic          rd_en, rd_strobe;
  logic          busy_q, prog_q, ld_msb_q;
  logic [AW-1:0] ld_addr_q;
  logic          t6_q, t6_next;
  logic [7:0]    id_code;
  logic [7:0]    status_byte;
  logic          poll_bit;
  rd_src_e       src;
  logic [7:0]    dq_d;

  srb_strobe u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_en(rd_en), .rd_strobe(rd_strobe)
  );

  srb_toggle u_toggle (
    .clk(clk), .rst(rst), .clr(op_start),
    .adv(rd_strobe & busy_q), .t_q(t6_q), .t_next(t6_next)
  );

  srb_ident #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_ident (
    .addr(rd_addr), .code(id_code)
  );

  // Operation context latched from the timer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      prog_q    <= 1'b0;
      ld_msb_q  <= 1'b0;
      ld_addr_q <= '0;
    end else if (op_start) begin
      busy_q    <= 1'b1;
      prog_q    <= op_is_prog;
      ld_msb_q  <= ld_data_msb;
      ld_addr_q <= ld_addr;
    end else if (op_done) begin
      busy_q    <= 1'b0;
    end
  end

  assign poll_bit    = prog_q && (rd_addr == ld_addr_q) ? ~ld_msb_q : 1'b0;
  assign status_byte = {poll_bit, t6_next, 6'b0};

  always_comb begin
    if (!rd_en)       src = SRC_NONE;
    else if (busy_q)  src = SRC_STATUS;
    else if (id_mode) src = SRC_IDENT;
    else              src = SRC_ARRAY;
  end

  always_comb begin
    case (src)
      SRC_STATUS: dq_d = status_byte;
      SRC_IDENT:  dq_d = id_code;
      SRC_ARRAY:  dq_d = arr_rdata;
      default:    dq_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= 8'h00;
      dq_oe  <= 1'b0;
    end else begin
      dq_out <= dq_d;
      dq_oe  <= rd_en;
    end
  end
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    arr_rdata,
  input logic          id_mode,
  input logic          op_start,
  input logic [7:0]    dq_out,
  input logic          dq_oe,
  input logic          busy_q,
  input logic          prog_q,
  input logic          ld_msb_q,
  input logic [AW-1:0] ld_addr_q,
  input logic          t6_q
);
  logic rd;
  assign rd = !ce_n && !oe_n && we_n;

  p_hiz_r1: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (!dq_oe && dq_out == 8'h00));

  p_poll_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && busy_q && prog_q && rd_addr == ld_addr_q) |=> (dq_out[7] == !$past(ld_msb_q)));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && busy_q) |=> (dq_out[5:0] == 6'b0));

  p_true_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && !busy_q && !id_mode) |=> (dq_out == $past(arr_rdata)));

  p_mfr_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && !busy_q && id_mode && rd_addr == '0) |=> (dq_out == 8'h1F));

  p_start_r6: assert property (@(posedge clk) disable iff (rst)
    op_start |=> (busy_q && !t6_q));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!dq_oe && dq_out == 8'h00 && !busy_q && !t6_q));
endmodule

bind status_readback srb_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .rd_addr(rd_addr), .arr_rdata(arr_rdata), .id_mode(id_mode),
  .op_start(op_start), .dq_out(dq_out), .dq_oe(dq_oe),
  .busy_q(busy_q), .prog_q(prog_q), .ld_msb_q(ld_msb_q),
  .ld_addr_q(ld_addr_q), .t6_q(t6_q)
);

// File: tb/status_readback_tb.sv
module status_readback_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    arr_rdata;
  logic          id_mode = 1'b0;
  logic          op_start = 1'b0, op_is_prog = 1'b0, op_done = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_data_msb = 1'b0;
  logic [7:0]    dq_out;
  logic          dq_oe;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state
  bit            m_busy = 0, m_prog = 0, m_msb = 0, m_t6 = 0, m_rdq = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0]    m_dq = 8'h00;
  bit            m_oe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign arr_rdata = arr_of(rd_addr);

  function automatic logic [7:0] id_of(input logic [AW-1:0] a);
    if (a > 3) return 8'h00;
    case (a[1:0])
      2'd0: return 8'h1F;
      2'd1: return 8'h07;
      2'd3: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  status_readback #(.AW(AW), .TOP_BOOT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .id_mode(id_mode),
    .op_start(op_start), .op_is_prog(op_is_prog), .op_done(op_done),
    .ld_addr(ld_addr), .ld_data_msb(ld_data_msb),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // one clock: update model with the inputs seen at the edge, then compare
  task automatic cyc(input string tag);
    bit rd, strobe, t;
    @(posedge clk);
    rd = !ce_n && !oe_n && we_n;
    strobe = rd && !m_rdq;
    if (rst) begin
      m_busy = 0; m_t6 = 0; m_oe = 0; m_dq = 8'h00; m_rdq = 0;
      m_prog = 0; m_msb = 0; m_addr = '0;
    end else begin
      if (!rd) m_dq = 8'h00;
      else if (m_busy) begin
        t = strobe ? !m_t6 : m_t6;
        m_dq = {(m_prog && rd_addr == m_addr) ? !m_msb : 1'b0, t, 6'b0};
      end else if (id_mode) m_dq = id_of(rd_addr);
      else m_dq = arr_of(rd_addr);
      m_oe = rd;
      if (op_start) begin
        m_busy = 1; m_prog = op_is_prog; m_msb = ld_data_msb; m_addr = ld_addr; m_t6 = 0;
      end else begin
        if (strobe && m_busy) m_t6 = !m_t6;
        if (op_done) m_busy = 0;
      end
      m_rdq = rd;
    end
    @(negedge clk);
    tests++;
    if (dq_oe !== m_oe || dq_out !== m_dq) begin
      fails++;
      $display("FAIL %s: dq_oe=%0b dq_out=%02h expected dq_oe=%0b dq_out=%02h",
               tag, dq_oe, dq_out, m_oe, m_dq);
    end
  endtask

  task automatic rd_set(input bit c, input bit o, input bit w, input logic [AW-1:0] a);
    ce_n = c; oe_n = o; we_n = w; rd_addr = a;
  endtask

  task automatic pulse_start(input bit prog, input logic [AW-1:0] a, input bit msb, input string tag);
    op_start = 1; op_is_prog = prog; ld_addr = a; ld_data_msb = msb;
    cyc(tag);
    op_start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);
    // R7: reset state
    cyc("R7"); cyc("R7");
    rst = 0;
    // R1: idle, outputs off
    cyc("R1");
    // R4: plain array read
    rd_set(0, 0, 1, 18'h01234); cyc("R4");
    rd_set(0, 0, 1, 18'h3ABCD); cyc("R4");
    rd_set(1, 1, 1, 18'h3ABCD); cyc("R1");
    // R1: write enable low blocks drive
    rd_set(0, 0, 0, 18'h00010); cyc("R1");
    rd_set(1, 1, 1, 18'h00010);
    // R6, R2, R3: program with msb=1
    pulse_start(1, 18'h00123, 1, "R6");
    rd_set(0, 0, 1, 18'h00123); cyc("R2");   // bit7=0, bit6=1
    cyc("R3");                               // held: bit6 stays 1
    rd_set(0, 1, 1, 18'h00123); cyc("R1");
    rd_set(0, 0, 1, 18'h00123); cyc("R3");   // oe fall: bit6=0
    rd_set(1, 0, 1, 18'h00123); cyc("R1");
    rd_set(0, 0, 1, 18'h00123); cyc("R3");   // ce fall: bit6=1
    rd_set(1, 1, 1, 18'h00456); cyc("R1");
    rd_set(0, 0, 1, 18'h00456); cyc("R2");   // other address: bit7=0
    // R4: done returns true data, toggling stops
    rd_set(1, 1, 1, 18'h00123); op_done = 1; cyc("R6"); op_done = 0;
    rd_set(0, 0, 1, 18'h00123); cyc("R4");
    rd_set(1, 1, 1, 18'h00123); cyc("R1");
    rd_set(0, 0, 1, 18'h00123); cyc("R4");
    rd_set(1, 1, 1, 18'h00123);
    // program with msb=0: poll bit reads 1
    pulse_start(1, 18'h20000, 0, "R6");
    rd_set(0, 0, 1, 18'h20000); cyc("R2");
    rd_set(1, 1, 1, 18'h20000);
    // start and done together: start wins, toggle restarts
    op_done = 1; pulse_start(0, 18'h00000, 1, "R6"); op_done = 0;
    rd_set(0, 0, 1, 18'h20000); cyc("R3");   // erase: bit7=0, bit6=1
    rd_set(1, 1, 1, 18'h20000); cyc("R1");
    // R5: identification ignored while busy
    id_mode = 1;
    rd_set(0, 0, 1, 18'h00000); cyc("R5");
    // R7: reset aborts busy
    rd_set(1, 1, 1, 18'h00000); rst = 1; cyc("R7"); rst = 0;
    for (int a = 0; a < 6; a++) begin
      rd_set(0, 0, 1, AW'(a)); cyc("R5");
      rd_set(1, 1, 1, AW'(a)); cyc("R1");
    end
    rd_set(0, 0, 1, 18'h10001); cyc("R5");
    rd_set(1, 1, 1, 18'h10001);
    id_mode = 0;
    cyc("R1");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      ce_n = ($urandom % 4) == 0;
      oe_n = ($urandom % 3) == 0;
      we_n = ($urandom % 8) != 0;
      sel = $urandom % 4;
      if (sel == 0)      rd_addr = m_addr;
      else if (sel == 1) rd_addr = AW'($urandom % 6);
      else               rd_addr = AW'($urandom);
      id_mode = ($urandom % 4) == 0;
      op_start = ($urandom % 40) == 0;
      op_is_prog = $urandom % 2;
      ld_addr = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
      ld_data_msb = $urandom % 2;
      op_done = ($urandom % 30) == 0;
      rst = ($urandom % 500) == 0;
      cyc(rst ? "R7" : "R3");
    end
    rst = 0; op_start = 0; op_done = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule